// File: doc/BRIEF.md
# Link State History Trace Buffer

This block keeps a history of a link-training state machine. Each clock it compares the incoming state code with the last one it stored. When the code differs, it writes one 32-bit word into a 64-slot ring. The word holds the state code, the link rate code in force and the low-power substate code. Samples that repeat the stored code are dropped, so the ring fills only as fast as the link actually moves.

Software uses a small register bus with two addresses: a control word and a status word. Each read of the status word returns the oldest unread entry and steps a persistent read position forward. When nothing unread is left, the read returns the newest entry a second time. Software treats two identical reads in a row as the end of the history. It can come back later and continue from where it stopped, after further transitions have been stored.

Top module: `link_trace_buf`

## Requirements
- R1: After reset the control word reads 0, `reg_rdata` is 0, and a status read returns 0, because no entry has been stored yet.
- R2: A write to the control address (0x0) changes control bit i (0..15) only when write-data bit i+16 is 1. A control read returns the 16 control bits in bits 15:0 and zeros above them.
- R3: Capture is on while control bit 0 is 1. Writing 0xffff0007 turns it on and writing 0xffff0000 turns it off. While capture is off, input state changes store nothing, and stored entries stay readable.
- R4: While capture is on, an entry is stored in the cycle after the input state code differs from the last stored code. The first sample after reset is always stored. A sample equal to the last stored code is not stored.
- R5: A status word carries the state code in bits 5:0, the substate code in bits 10:8 and the rate code in bits 22:20, all taken in the sampling cycle. Every other bit is 0.
- R6: Status reads at address 0x4 return stored entries oldest first. Each read moves the read position on by exactly one while unread entries exist.
- R7: A status read with no unread entry returns the most recently stored entry and leaves the read position where it is.
- R8: Entries stored after a partial read-out follow the entries still unread, and reading resumes at the saved position without skipping any.
- R9: When an entry is stored while 64 are unread, the oldest is overwritten and the read position moves with it. After 64+k changes, the reads return the newest 64 in order.
- R10: `reg_rdata` is updated in the clock edge that samples `reg_rd` and holds its value until the next read strobe. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_in | input | 6 | Link-training state code being observed |
| rate_in | input | 3 | Current link rate code |
| substate_in | input | 3 | Current low-power substate code |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 4 | Register byte address (0x0 control, 0x4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A state change driven before a rising edge is stored at the edge that follows, so the first read after it can already see the entry. A read strobe is sampled at one edge, and `reg_rdata` carries the result from that edge until the next strobe. The bench changes inputs and strobes only on falling edges and samples read data on the next falling edge, half a period after the update. A bench model of the ring is advanced in the same order as those edges, so each expected word is the one due at the moment it is sampled.

// File: rtl/link_trace_pkg.sv
package link_trace_pkg;

    localparam int STATE_W = 6;
    localparam int RATE_W  = 3;
    localparam int SUB_W   = 3;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h4;

    // bits of a status word that may be non-zero
    localparam logic [WORD_W-1:0] FIELD_MASK = 32'h0070_073F;

    typedef struct packed {
        logic [RATE_W-1:0]  rate;
        logic [SUB_W-1:0]   sub;
        logic [STATE_W-1:0] code;
    } trace_sample_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    function automatic logic [WORD_W-1:0] pack_word(trace_sample_t s);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[5:0]   = s.code;
        w[10:8]  = s.sub;
        w[22:20] = s.rate;
        return w;
    endfunction

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a == ADDR_CTRL) return SEL_CTRL;
        if (a == ADDR_STAT) return SEL_STAT;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/lt_change_detect.sv
module lt_change_detect
    import link_trace_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  trace_sample_t        sample,
    output logic                 cap_o,
    output logic [WORD_W-1:0]    word_o
);

    logic [STATE_W-1:0] prev_q;
    logic               seen_q;

    assign cap_o  = en && (!seen_q || (sample.code != prev_q));
    assign word_o = pack_word(sample);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else if (cap_o) begin
            prev_q <= sample.code;
            seen_q <= 1'b1;
        end
    end

    // a store leaves the stored code equal to the sampled code
    assert_prev_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        cap_o |=> (prev_q == $past(sample.code)) && seen_q);

    // with no store, the remembered code does not move
    assert_prev_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !cap_o |=> $stable(prev_q));

endmodule

// File: rtl/lt_ring.sv
module lt_ring
    import link_trace_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] peek_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] last_q;
    logic              unread, adv, drop_old;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign unread   = (cnt_q != '0);
    assign adv      = rd_en && unread;
    assign drop_old = wr_en && (cnt_q == FULL);
    assign peek_o   = unread ? mem[rd_ptr_q] : last_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr_q] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            last_q   <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= bump(wr_ptr_q);
                last_q   <= wr_word;
            end
            if (adv || drop_old) rd_ptr_q <= bump(rd_ptr_q);
            case ({wr_en, adv})
                2'b10:   if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !unread) |=> $stable(rd_ptr_q));

    assert_full_follow_R9: assert property (@(posedge clk) disable iff (rst)
        drop_old |=> (rd_ptr_q == bump($past(rd_ptr_q))) && (cnt_q == FULL));

    assert_read_step_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/lt_ctrl_reg.sv
module lt_ctrl_reg
    import link_trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [15:0]       ctrl_o,
    output logic              cap_en_o
);

    logic [15:0] ctrl_q;
    logic [15:0] bit_mask;

    assign bit_mask = wdata[31:16];
    assign ctrl_o   = ctrl_q;
    assign cap_en_o = ctrl_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= (ctrl_q & ~bit_mask) | (wdata[15:0] & bit_mask);
        end
    end

    assert_mask_guard_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wdata[31:16] == 16'h0)) |=> $stable(ctrl_q));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/link_trace_buf.sv
module link_trace_buf
    import link_trace_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  state_in,
    input  logic [2:0]  rate_in,
    input  logic [2:0]  substate_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);

    trace_sample_t     sample;
    reg_sel_e          sel;
    logic              cap_en, cap;
    logic [WORD_W-1:0] cap_word, peek;
    logic [15:0]       ctrl;
    logic [WORD_W-1:0] rdata_q;
    logic              stat_rd_q;

    assign sample = '{rate: rate_in, sub: substate_in, code: state_in};
    assign sel    = decode_addr(reg_addr);

    lt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && (sel == SEL_CTRL)),
        .wdata    (reg_wdata),
        .ctrl_o   (ctrl),
        .cap_en_o (cap_en)
    );

    lt_change_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .en     (cap_en),
        .sample (sample),
        .cap_o  (cap),
        .word_o (cap_word)
    );

    lt_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cap),
        .wr_word (cap_word),
        .rd_en   (reg_rd && (sel == SEL_STAT)),
        .peek_o  (peek)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q   <= '0;
            stat_rd_q <= 1'b0;
        end else if (reg_rd) begin
            stat_rd_q <= (sel == SEL_STAT);
            case (sel)
                SEL_CTRL: rdata_q <= {16'h0, ctrl};
                SEL_STAT: rdata_q <= peek;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;

    assert_field_zero_R5: assert property (@(posedge clk) disable iff (rst)
        stat_rd_q |-> ((reg_rdata & ~FIELD_MASK) == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    assert_off_no_store_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] |-> !cap);

endmodule

// File: tb/link_trace_buf_tb_top.sv
`timescale 1ns/1ps
module link_trace_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  state_in = '0;
    logic [2:0]  rate_in = '0;
    logic [2:0]  substate_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;

    link_trace_buf dut_i (
        .clk(clk), .rst(rst), .state_in(state_in), .rate_in(rate_in),
        .substate_in(substate_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the ring
    logic [31:0] bm [64];
    int          bcnt = 0, brd = 0, bwr = 0;
    logic [31:0] blast = '0;
    int          bprev = 0;
    bit          bseen = 1'b0;
    logic [15:0] bctrl = '0;

    function automatic logic [31:0] mk(int s, int r, int u);
        return (32'(r & 7) << 20) | (32'(u & 7) << 8) | 32'(s & 63);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_sample();
        if (bctrl[0] && (!bseen || int'(state_in) != bprev)) begin
            if (bcnt == 64) brd = (brd + 1) % 64;
            else bcnt++;
            bm[bwr] = mk(state_in, rate_in, substate_in);
            blast   = bm[bwr];
            bwr     = (bwr + 1) % 64;
            bprev   = state_in;
            bseen   = 1'b1;
        end
    endtask

    task automatic drive(int s, int r, int u);
        @(negedge clk);
        state_in = 6'(s); rate_in = 3'(r); substate_in = 3'(u);
        model_sample();
    endtask

    task automatic wreg(logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        bctrl = (bctrl & ~d[31:16]) | (d[15:0] & d[31:16]);
        @(negedge clk);
        model_sample();
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rd_stat(string req);
        logic [31:0] v, e;
        e = (bcnt != 0) ? bm[brd] : blast;
        if (bcnt != 0) begin brd = (brd + 1) % 64; bcnt--; end
        rd(4'h4, v);
        check(v == e, req, v, e);
    endtask

    initial begin
        logic [31:0] v, first;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == 0, "R1 rdata after reset", reg_rdata, 0);
        rd(4'h0, v); check(v == 0, "R1 control reset", v, 0);
        rd(4'h4, v); check(v == 0, "R1 empty status", v, 0);
        rd(4'h8, v); check(v == 0, "R10 unmapped read", v, 0);

        // R3: changes while off are ignored
        drive(5, 1, 0); drive(9, 2, 0);
        rd_stat("R3 disabled capture ignored");

        // R2/R3 enable, mask-guarded write
        wreg(32'hffff_0007);
        rd(4'h0, v); check(v == 32'h7, "R2 control enable value", v, 32'h7);
        wreg(32'h0000_0000);
        rd(4'h0, v); check(v == 32'h7, "R2 masked write ignored", v, 32'h7);

        // R4/R5/R6: sweep of changes with repeats
        for (int i = 0; i < 20; i++) begin
            drive((i * 7 + 3) % 61, i % 8, (i * 3) % 8);
            drive((i * 7 + 3) % 61, i % 8, (i * 3) % 8); // repeat, R4
        end
        for (int i = 0; i < 21; i++) rd_stat("R6 R5 R4 ordered read");
        rd_stat("R7 empty repeats last");
        rd_stat("R7 second repeat");

        // R10: held data
        first = reg_rdata;
        repeat (3) @(negedge clk);
        check(reg_rdata == first, "R10 rdata holds", reg_rdata, first);

        // R8: partial read then resume
        for (int i = 0; i < 5; i++) drive(40 + i, 7 - i, i);
        for (int i = 0; i < 3; i++) rd_stat("R8 partial read");
        for (int i = 0; i < 4; i++) drive(50 + i, i, 7 - i);
        rd(4'h0, v); check(v == 32'h7, "R6 control read no advance", v, 32'h7);
        for (int i = 0; i < 6; i++) rd_stat("R8 resumed read");
        rd_stat("R7 end after resume");

        // R3: disable keeps entries readable, ignores changes
        for (int i = 0; i < 3; i++) drive(20 + i, 1, 1);
        wreg(32'hffff_0000);
        rd(4'h0, v); check(v == 32'h0, "R3 disable value", v, 0);
        drive(33, 3, 3); drive(34, 4, 4);
        for (int i = 0; i < 4; i++) rd_stat("R3 readable while off");

        // R2: single-bit masked write clears bit 0 only
        wreg(32'hffff_0007);
        wreg(32'h0001_0000);
        rd(4'h0, v); check(v == 32'h6, "R2 per-bit mask", v, 32'h6);
        drive(12, 5, 2);
        rd_stat("R3 off after masked clear");

        // R9: overflow
        wreg(32'hffff_0007);
        for (int i = 0; i < 70; i++) drive(i % 64, i % 5, (i + 1) % 8);
        for (int i = 0; i < 64; i++) rd_stat("R9 overflow keeps newest");
        rd_stat("R9 R7 end after overflow");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule